// File: doc/BRIEF.md
# Eye-Monitor Receiver Supply Scaling Controller

This block closes a slow power-versus-sensitivity loop around an optical receiver front end. Each clock it takes a four-bit word from the data slicers, one bit per quadrature sampling phase. It also takes the matching word from an eye-monitor slicer, which samples on the same phases but with an offset threshold set from outside. The block treats a disagreement between the two as a marginal eye. It counts such disagreements only on the pattern where inter-symbol interference is worst: a one that directly follows a zero.

After a programmable number of words, the accumulated count picks one of four outcomes for the six-bit code of the supply regulator DAC:
- a clean window lowers the code by one to save power;
- a window with a few errors keeps the code where it is, so that the loop does not dither;
- a window that reaches a lower error threshold raises the code by one;
- a window that passes an upper error threshold raises it by two.

An enable input lets the monitor run only part of the time. The eye-monitor threshold value is passed through to the monitor slicer with one register stage.

Top module: `eye_supply_adapt`

## Requirements
- R1: While reset is asserted and after its release, `supplyCode` is 63 (the nominal, highest supply) and `eyeThrOut` is 0 until a later clock edge loads it.
- R2: Within a word, lane 0 is the earliest bit in time and lane 3 the latest. A lane is examined only if its data bit is 1 and the bit just before it in time is 0. Lanes on any other data pattern never add to the error count.
- R3: For lane 0, the bit just before it is lane 3 of the word from the previous clock, which is carried across words. The first word after reset is treated as if it followed a 1.
- R4: An examined lane counts one error when its eye-monitor bit differs from its data bit.
- R5: A decision is applied at the clock edge that takes in the last word of a window of `windowLen` words. The value 0 behaves as 1. `supplyCode` does not change at any other edge, and the word and error counts restart at zero for every window.
- R6: A window with zero errors lowers `supplyCode` by one. This rule takes precedence over the threshold comparisons.
- R7: A window whose error count is nonzero and below `errLoThr` leaves `supplyCode` unchanged.
- R8: A window whose error count is at least `errLoThr` and at most `errHiThr` raises `supplyCode` by one. A count above `errHiThr` raises it by two.
- R9: `supplyCode` saturates at 0 and at 63 and never wraps.
- R10: The window error count saturates at 255 and does not roll over.
- R11: While `enable` is low, `supplyCode` holds its value and the window restarts. After `enable` returns high, a full new window of words counts before the next decision.
- R12: `eyeThrOut` equals the value `eyeThrIn` had at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Adaptation enable; low freezes the code and restarts the window |
| dataBits | input | 4 | Data slicer bits, lane 0 earliest in time |
| eyeBits | input | 4 | Eye-monitor slicer bits on the same phases |
| windowLen | input | 12 | Window length in words |
| errLoThr | input | 8 | Error count at which the code starts to rise |
| errHiThr | input | 8 | Error count above which the code rises by two |
| eyeThrIn | input | 6 | Eye-monitor offset threshold from outside |
| supplyCode | output | 6 | Regulator DAC code |
| eyeThrOut | output | 6 | Registered eye-monitor threshold to the slicer |

## Verification
The stimulus puts errors on lanes that are not on the zero-then-one pattern. A controller that counts every mismatch would raise the supply when it should lower it. Runs of `0001` words test the lane-3-to-lane-0 carry: a design that drops the previous word's last bit loses one error per window and holds instead of stepping up. Other tests drive the code to both ends of its range, and run a long window whose raw count of 400 would wrap to a value inside the hold band if the counter were not saturating. A partial window is interrupted by `enable` going low, so a design that keeps stale counts across the pause ends its next window early and with the wrong outcome.

// File: rtl/eye_supply_pkg.sv
`timescale 1ns/1ps
package eye_supply_pkg;

  // Strobes the window control sends to the datapath each clock.
  typedef struct packed {
    logic clearAcc;       // drop the running error count
    logic accumulate;     // add this word's errors to the running count
    logic applyDecision;  // last word of the window: update the code
  } winStrobes_t;

  typedef enum logic [1:0] {
    STEP_DOWN = 2'd0,
    STEP_HOLD = 2'd1,
    STEP_UP1  = 2'd2,
    STEP_UP2  = 2'd3
  } supplyStep_e;

endpackage

// File: rtl/esa_pattern_check.sv
`timescale 1ns/1ps
module esa_pattern_check #(
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] dataBits,
  input  logic [LANES-1:0] eyeBits,
  input  logic             prevBit,
  output logic [CNT_W-1:0] errCount
);

  logic [LANES-1:0] laneErr;

  // Lane 0 pairs with the carried bit; other lanes pair with their neighbour.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic pred;
    if (g == 0) begin : g_first
      assign pred = prevBit;
    end else begin : g_rest
      assign pred = dataBits[g-1];
    end
    assign laneErr[g] = ~pred & dataBits[g] & (eyeBits[g] ^ dataBits[g]);
  end

  always_comb begin
    errCount = '0;
    for (int i = 0; i < LANES; i++) begin
      errCount = errCount + CNT_W'(laneErr[i]);
    end
  end

endmodule

// File: rtl/esa_window_ctrl.sv
`timescale 1ns/1ps
module esa_window_ctrl
  import eye_supply_pkg::*;
#(
  parameter int WIN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic [WIN_W-1:0] windowLen,
  output winStrobes_t      strobes
);

  logic [WIN_W-1:0] wordCnt;
  logic             lastWord;

  // A length of zero compares like a length of one.
  assign lastWord = ({1'b0, wordCnt} + (WIN_W+1)'(1)) >= {1'b0, windowLen};

  always_comb begin
    strobes = '0;
    if (!enable) begin
      strobes.clearAcc = 1'b1;
    end else if (lastWord) begin
      strobes.applyDecision = 1'b1;
      strobes.clearAcc      = 1'b1;
    end else begin
      strobes.accumulate = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wordCnt <= '0;
    end else if (!enable || lastWord) begin
      wordCnt <= '0;
    end else begin
      wordCnt <= wordCnt + WIN_W'(1);
    end
  end

endmodule

// File: rtl/esa_supply_datapath.sv
`timescale 1ns/1ps
module esa_supply_datapath
  import eye_supply_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CODE_W = 6,
  parameter int ERR_W  = 8,
  parameter int THR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  winStrobes_t       strobes,
  input  logic [LANES-1:0]  dataBits,
  input  logic [LANES-1:0]  eyeBits,
  input  logic [ERR_W-1:0]  errLoThr,
  input  logic [ERR_W-1:0]  errHiThr,
  input  logic [THR_W-1:0]  eyeThrIn,
  output logic [CODE_W-1:0] supplyCode,
  output logic [THR_W-1:0]  eyeThrOut
);

  localparam int CNT_W = $clog2(LANES + 1);
  localparam logic [CODE_W-1:0] CODE_MAX = '1;
  localparam logic [ERR_W-1:0]  ERR_MAX  = '1;

  logic              lastBit;
  logic [CNT_W-1:0]  wordErrs;
  logic [ERR_W-1:0]  errAcc;
  logic [ERR_W:0]    errSumWide;
  logic [ERR_W-1:0]  errSum;
  supplyStep_e       step;
  logic [CODE_W+1:0] codeWide;
  logic [CODE_W-1:0] nextCode;

  esa_pattern_check #(
    .LANES (LANES),
    .CNT_W (CNT_W)
  ) u_pattern (
    .dataBits (dataBits),
    .eyeBits  (eyeBits),
    .prevBit  (lastBit),
    .errCount (wordErrs)
  );

  // Saturating running sum including the current word.
  assign errSumWide = {1'b0, errAcc} + (ERR_W+1)'(wordErrs);
  assign errSum     = errSumWide[ERR_W] ? ERR_MAX : errSumWide[ERR_W-1:0];

  always_comb begin
    if (errSum == '0) begin
      step = STEP_DOWN;
    end else if (errSum > errHiThr) begin
      step = STEP_UP2;
    end else if (errSum >= errLoThr) begin
      step = STEP_UP1;
    end else begin
      step = STEP_HOLD;
    end
  end

  assign codeWide = {2'b00, supplyCode};

  always_comb begin
    nextCode = supplyCode;
    unique case (step)
      STEP_DOWN: nextCode = (supplyCode == '0) ? '0 : supplyCode - CODE_W'(1);
      STEP_HOLD: nextCode = supplyCode;
      STEP_UP1:  nextCode = (codeWide + (CODE_W+2)'(1) > (CODE_W+2)'(CODE_MAX))
                            ? CODE_MAX : supplyCode + CODE_W'(1);
      STEP_UP2:  nextCode = (codeWide + (CODE_W+2)'(2) > (CODE_W+2)'(CODE_MAX))
                            ? CODE_MAX : supplyCode + CODE_W'(2);
      default:   nextCode = supplyCode;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastBit    <= 1'b1;
      errAcc     <= '0;
      supplyCode <= CODE_MAX;
      eyeThrOut  <= '0;
    end else begin
      lastBit   <= dataBits[LANES-1];
      eyeThrOut <= eyeThrIn;
      if (strobes.applyDecision) begin
        supplyCode <= nextCode;
      end
      if (strobes.clearAcc) begin
        errAcc <= '0;
      end else if (strobes.accumulate) begin
        errAcc <= errSum;
      end
    end
  end

endmodule

// File: rtl/eye_supply_adapt.sv
`timescale 1ns/1ps
module eye_supply_adapt
  import eye_supply_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int CODE_W = 6,
  parameter int ERR_W  = 8,
  parameter int WIN_W  = 12,
  parameter int THR_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [LANES-1:0]  dataBits,
  input  logic [LANES-1:0]  eyeBits,
  input  logic [WIN_W-1:0]  windowLen,
  input  logic [ERR_W-1:0]  errLoThr,
  input  logic [ERR_W-1:0]  errHiThr,
  input  logic [THR_W-1:0]  eyeThrIn,
  output logic [CODE_W-1:0] supplyCode,
  output logic [THR_W-1:0]  eyeThrOut
);

  winStrobes_t strobes;

  esa_window_ctrl #(
    .WIN_W (WIN_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .windowLen (windowLen),
    .strobes   (strobes)
  );

  esa_supply_datapath #(
    .LANES  (LANES),
    .CODE_W (CODE_W),
    .ERR_W  (ERR_W),
    .THR_W  (THR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dataBits   (dataBits),
    .eyeBits    (eyeBits),
    .errLoThr   (errLoThr),
    .errHiThr   (errHiThr),
    .eyeThrIn   (eyeThrIn),
    .supplyCode (supplyCode),
    .eyeThrOut  (eyeThrOut)
  );

endmodule

// File: rtl/eye_supply_adapt_chk.sv
`timescale 1ns/1ps
module eye_supply_adapt_chk
  import eye_supply_pkg::*;
#(
  parameter int CODE_W = 6,
  parameter int THR_W  = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic [THR_W-1:0]  eyeThrIn,
  input logic [THR_W-1:0]  eyeThrOut,
  input logic [CODE_W-1:0] supplyCode,
  input winStrobes_t       strobes
);

  // R6: a falling code only ever drops by one step
  a_r6_down_by_one: assert property (@(posedge clk) disable iff (!rstN)
    (supplyCode < $past(supplyCode)) |-> (supplyCode == $past(supplyCode) - CODE_W'(1)));

  // R8: a rising code rises by at most two steps
  a_r8_up_bounded: assert property (@(posedge clk) disable iff (!rstN)
    (supplyCode > $past(supplyCode)) |-> ((supplyCode - $past(supplyCode)) <= CODE_W'(2)));

  // R11: a disabled cycle leaves the code untouched
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rstN)
    $past(!enable) |-> (supplyCode == $past(supplyCode)));

  // R12: threshold passthrough is one register late
  a_r12_thr_pass: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (eyeThrOut == $past(eyeThrIn)));

  // R5: control never asks to accumulate and decide in the same word
  a_r5_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.accumulate, strobes.applyDecision}));

endmodule

bind eye_supply_adapt eye_supply_adapt_chk #(
  .CODE_W (CODE_W),
  .THR_W  (THR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enable     (enable),
  .eyeThrIn   (eyeThrIn),
  .eyeThrOut  (eyeThrOut),
  .supplyCode (supplyCode),
  .strobes    (strobes)
);

// File: tb/eye_supply_adapt_tb.sv
`timescale 1ns/1ps
module eye_supply_adapt_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [3:0]  dataBits = '0;
  logic [3:0]  eyeBits = '0;
  logic [11:0] windowLen = 12'd4;
  logic [7:0]  errLoThr = 8'd3;
  logic [7:0]  errHiThr = 8'd6;
  logic [5:0]  eyeThrIn = '0;
  logic [5:0]  supplyCode;
  logic [5:0]  eyeThrOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  eye_supply_adapt u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .dataBits   (dataBits),
    .eyeBits    (eyeBits),
    .windowLen  (windowLen),
    .errLoThr   (errLoThr),
    .errHiThr   (errHiThr),
    .eyeThrIn   (eyeThrIn),
    .supplyCode (supplyCode),
    .eyeThrOut  (eyeThrOut)
  );

  // {data[19:16], eye flip mask[15:12], window words[11:6], expected code[5:0]}
  // thresholds lo=3 hi=6; each row is one full window
  localparam int NVEC = 10;
  localparam logic [19:0] VEC [0:NVEC-1] = '{
    {4'b1010, 4'b0000, 6'd4, 6'd62},  // R6 clean window
    {4'b1010, 4'b0101, 6'd4, 6'd61},  // R2 flips on non-pattern lanes
    {4'b1010, 4'b0010, 6'd2, 6'd61},  // R7 two errors hold
    {4'b1010, 4'b0010, 6'd3, 6'd62},  // R8 three errors up one
    {4'b1010, 4'b1010, 6'd4, 6'd63},  // R8 eight errors up two, R9 cap
    {4'b1010, 4'b1010, 6'd3, 6'd63},  // R9 six errors, at cap
    {4'b1111, 4'b1111, 6'd4, 6'd62},  // R2 all ones: nothing examined
    {4'b0001, 4'b0001, 6'd3, 6'd62},  // R3 first word follows a 1: two errors
    {4'b0001, 4'b0001, 6'd3, 6'd63},  // R3 carried 0: three errors
    {4'b0000, 4'b1111, 6'd5, 6'd62}   // R4 no ones: clean
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stepWord(input logic [3:0] d, input logic [3:0] m);
    dataBits = d;
    eyeBits  = d ^ m;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int prevCode;
    eyeThrIn = 6'h15;
    repeat (3) @(posedge clk);
    #1;
    check("R1 code in reset", int'(supplyCode), 63);
    check("R1 threshold in reset", int'(eyeThrOut), 0);
    rstN = 1'b1;
    eyeThrIn = 6'h00;
    check("R1 code after release", int'(supplyCode), 63);

    enable = 1'b1;
    for (int v = 0; v < NVEC; v++) begin
      windowLen = 12'(VEC[v][11:6]);
      prevCode  = int'(supplyCode);
      for (int w = 0; w < int'(VEC[v][11:6]); w++) begin
        if (w == int'(VEC[v][11:6]) - 1 && w > 0)
          check("R5 code steady inside window", int'(supplyCode), prevCode);
        stepWord(VEC[v][19:16], VEC[v][15:12]);
      end
      check($sformatf("R5 window row %0d", v), int'(supplyCode), int'(VEC[v][5:0]));
    end

    // R12 passthrough, one edge late
    eyeThrIn = 6'h2A;
    check("R12 before edge", int'(eyeThrOut), 0);
    @(posedge clk);
    #1;
    check("R12 after edge", int'(eyeThrOut), 42);

    // R11: partial window with errors, pause, then restart
    windowLen = 12'd4;
    stepWord(4'b1010, 4'b1010);
    stepWord(4'b1010, 4'b1010);
    enable = 1'b0;
    for (int i = 0; i < 3; i++) stepWord(4'b1010, 4'b1010);
    check("R11 frozen while disabled", int'(supplyCode), 62);
    enable = 1'b1;
    for (int i = 0; i < 3; i++) stepWord(4'b0000, 4'b0000);
    check("R11 window restarted", int'(supplyCode), 62);
    stepWord(4'b0000, 4'b0000);
    check("R11 clean fresh window", int'(supplyCode), 61);

    // R9 floor
    windowLen = 12'd1;
    for (int i = 0; i < 70; i++) stepWord(4'b0000, 4'b0000);
    check("R9 floor at zero", int'(supplyCode), 0);

    // R10 saturating count: 400 errors must not wrap to 144
    errLoThr  = 8'd200;
    errHiThr  = 8'd254;
    windowLen = 12'd200;
    for (int i = 0; i < 200; i++) stepWord(4'b1010, 4'b1010);
    check("R10 saturated count steps up two", int'(supplyCode), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule